// File: doc/BRIEF.md
# Three-Phase Sampled Hysteresis Current Controller

This block decides the switching state of each leg of a three-phase voltage source inverter so that the inductor current in every leg follows a numeric reference. For each phase it builds an upper and a lower limit by adding a shared band half-width to the reference and subtracting it. A fresh feedback sample that lies above the upper limit makes the leg pull its current down. A sample that lies below the lower limit makes the leg push its current up. A sample inside the band leaves the leg as it is.

All decisions are taken on sampled data. A phase only re-evaluates when its feedback-valid strobe is high. Between samples the last decision is held. A counter per leg inserts a blanking interval whenever the active gate changes, so that the high-side and low-side switches never conduct together. The three phases share only the band half-width. That value is captured into a register by a load strobe, and no leg drives anything until it has been loaded.

Top module: `hcc_ctrl`

## Requirements
- R1: After reset every `gate_hi` and `gate_lo` bit is 0 and each leg has no direction.
- R2: Each leg's upper limit is min(ref + h, 2047) and its lower limit is max(ref − h, −2048), computed without wrap-around, where h is the loaded half-width (0..2047).
- R3: On a valid sample, feedback strictly above the upper limit selects direction down (`gate_lo` = 1 once settled). Feedback strictly below the lower limit selects direction up (`gate_hi` = 1 once settled).
- R4: A valid sample with feedback in [lower, upper], both ends included, leaves that leg's direction unchanged.
- R5: When `fb_valid[p]` is 0, leg p keeps its direction whatever its feedback and reference inputs do.
- R6: Samples that arrive before the first `cfg_load` are ignored. A leg has no direction, and both its gates stay low, until a loaded configuration and an out-of-band sample are both present.
- R7: `gate_hi[p]` and `gate_lo[p]` are never 1 together. For a valid sample at edge e that reverses an active leg, the old gate stays on after edge e, both gates are low from edge e+1, and the new gate rises at edge e+DEAD_CYC+2.
- R8: From the all-off state, the gate rises at edge a+DEAD_CYC. Here a is the first edge at which the leg has a direction and `enable` is 1.
- R9: With `enable` at 0, all gates are low after the next edge, and each leg keeps its direction for use when `enable` returns.
- R10: The phases act independently: a sample on one phase never changes the gates of another phase.
- R11: `cfg_load` at an edge captures `hyst_in`, and samples taken at later edges use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | 0 forces all gates low |
| cfg_load | input | 1 | Strobe that captures `hyst_in` |
| hyst_in | input | 12 | Band half-width, signed, expected 0..2047 |
| ref_in | input | 36 | Three signed 12-bit references, phase p at bits [12p+11:12p] |
| fb_in | input | 36 | Three signed 12-bit feedback samples, same packing |
| fb_valid | input | 3 | Per-phase strobe marking a fresh feedback sample |
| gate_hi | output | 3 | High-side gate per phase (1 drives current up) |
| gate_lo | output | 3 | Low-side gate per phase (1 drives current down) |

## Verification
The limit checks take for granted that the loaded half-width is non-negative, so that the upper limit never sits below the reference and the lower limit never sits above it. The stimulus therefore only loads values from 0 to 2047. Feedback values are clamped to the 12-bit range before being applied. Loads are never issued in the same cycle as a sample. The sweep mixes references at and near both rails with half-widths from zero to full scale, which drives the saturating limits and both inclusive band edges.

// File: rtl/hcc_pkg.sv
// Shared types for the hysteresis current controller.
package hcc_pkg;
    // Leg direction: NONE until first decision, UP drives current up, DOWN drives it down.
    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_UP   = 2'd1,
        DRV_DOWN = 2'd2
    } drive_t;
endpackage

// File: rtl/hcc_band.sv
// Saturating band limits: upper = ref + h, lower = ref - h, clamped to the
// signed W-bit range. Assumes h is non-negative. clk/rst_n serve the checks only.
module hcc_band #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] ref_i,
    input  logic signed [W-1:0] hyst_i,
    output logic signed [W-1:0] upper_o,
    output logic signed [W-1:0] lower_o
);
    localparam logic signed [W:0] MAXV = (W+1)'((2**(W-1)) - 1);
    localparam logic signed [W:0] MINV = -(W+1)'(2**(W-1));

    logic signed [W:0] r_ext, h_ext, sum_up, sum_dn;

    // Widen by one bit and clamp both sums.
    always_comb begin
        r_ext  = {ref_i[W-1], ref_i};
        h_ext  = {hyst_i[W-1], hyst_i};
        sum_up = r_ext + h_ext;
        sum_dn = r_ext - h_ext;
        upper_o = (sum_up > MAXV) ? MAXV[W-1:0] : sum_up[W-1:0];
        lower_o = (sum_dn < MINV) ? MINV[W-1:0] : sum_dn[W-1:0];
    end

    // R2: with a non-negative band the limits never cross the reference.
    a_r2_upper_ge_ref: assert property (@(posedge clk) disable iff (!rst_n)
        !hyst_i[W-1] |-> (upper_o >= ref_i));
    a_r2_lower_le_ref: assert property (@(posedge clk) disable iff (!rst_n)
        !hyst_i[W-1] |-> (lower_o <= ref_i));
endmodule

// File: rtl/hcc_dirlatch.sv
// Set/reset direction state of one leg. Updates only on a qualified sample;
// inside the band or without a sample the direction is held.
module hcc_dirlatch
    import hcc_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_i,
    input  logic signed [W-1:0] fb_i,
    input  logic signed [W-1:0] upper_i,
    input  logic signed [W-1:0] lower_i,
    output drive_t              dir_o
);
    // Set on excursion above, reset on excursion below, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_o <= DRV_NONE;
        end else if (sample_i) begin
            if (fb_i > upper_i) begin
                dir_o <= DRV_DOWN;
            end else if (fb_i < lower_i) begin
                dir_o <= DRV_UP;
            end
        end
    end

    // R3: excursions pick the opposing direction.
    a_r3_above_goes_down: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && (fb_i > upper_i)) |=> (dir_o == DRV_DOWN));
    a_r3_below_goes_up: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && (fb_i < lower_i) && (fb_i <= upper_i)) |=> (dir_o == DRV_UP));
    // R4: in-band sample holds.
    a_r4_inband_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && (fb_i <= upper_i) && (fb_i >= lower_i)) |=> $stable(dir_o));
    // R5: no sample, no change.
    a_r5_no_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(dir_o));
endmodule

// File: rtl/hcc_deadtime.sv
// Gate generator with blanking. On any change of target the active gate drops
// at once, a counter of DEAD_CYC cycles runs with both gates low, then the new
// gate rises. Assumes DEAD_CYC >= 1.
module hcc_deadtime
    import hcc_pkg::*;
#(
    parameter int DEAD_CYC = 100
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable_i,
    input  drive_t dir_i,
    output logic   gate_hi_o,
    output logic   gate_lo_o
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DEAD = CW'(DEAD_CYC);

    drive_t        target;
    logic [CW-1:0] cnt;
    logic          mismatch;

    // Target is the latched direction, or nothing when disabled.
    always_comb begin
        target   = enable_i ? dir_i : DRV_NONE;
        mismatch = (gate_hi_o && (target != DRV_UP)) ||
                   (gate_lo_o && (target != DRV_DOWN));
    end

    // Drop, blank for DEAD cycles, then raise the gate matching the target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hi_o <= 1'b0;
            gate_lo_o <= 1'b0;
            cnt       <= DEAD;
        end else if (target == DRV_NONE || mismatch) begin
            gate_hi_o <= 1'b0;
            gate_lo_o <= 1'b0;
            cnt       <= DEAD;
        end else if (!gate_hi_o && !gate_lo_o) begin
            if (cnt == '0) begin
                gate_hi_o <= (target == DRV_UP);
                gate_lo_o <= (target == DRV_DOWN);
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Check-only run length of cycles with both gates low, saturating at DEAD.
    logic [CW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (gate_hi_o || gate_lo_o) begin
            low_run <= '0;
        end else if (low_run != DEAD) begin
            low_run <= low_run + 1'b1;
        end
    end

    // R7: never both on.
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_o && gate_lo_o));
    // R7: every rising gate follows a full blanking window.
    a_r7_blank_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi_o) || $rose(gate_lo_o)) |-> (low_run == DEAD));
    // R9: disable turns the leg off by the next edge.
    a_r9_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!gate_hi_o && !gate_lo_o));
endmodule

// File: rtl/hcc_ctrl.sv
// Three-phase sampled hysteresis current controller. Holds the shared band
// half-width, and per phase computes saturating limits, latches a direction
// on qualified samples and drives blanked complementary gates.
module hcc_ctrl
    import hcc_pkg::*;
#(
    parameter int W        = 12,
    parameter int PHASES   = 3,
    parameter int DEAD_CYC = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                cfg_load,
    input  logic [W-1:0]        hyst_in,
    input  logic [PHASES*W-1:0] ref_in,
    input  logic [PHASES*W-1:0] fb_in,
    input  logic [PHASES-1:0]   fb_valid,
    output logic [PHASES-1:0]   gate_hi,
    output logic [PHASES-1:0]   gate_lo
);
    logic signed [W-1:0] hyst_q;
    logic                cfg_loaded;

    // Configuration register and its loaded flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hyst_q     <= '0;
            cfg_loaded <= 1'b0;
        end else if (cfg_load) begin
            hyst_q     <= hyst_in;
            cfg_loaded <= 1'b1;
        end
    end

    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        logic signed [W-1:0] upper, lower;
        drive_t              dir;

        hcc_band #(.W(W)) u_band (
            .clk     (clk),
            .rst_n   (rst_n),
            .ref_i   (ref_in[p*W +: W]),
            .hyst_i  (hyst_q),
            .upper_o (upper),
            .lower_o (lower)
        );

        hcc_dirlatch #(.W(W)) u_dir (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_i (fb_valid[p] && cfg_loaded),
            .fb_i     (fb_in[p*W +: W]),
            .upper_i  (upper),
            .lower_i  (lower),
            .dir_o    (dir)
        );

        hcc_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable_i  (enable),
            .dir_i     (dir),
            .gate_hi_o (gate_hi[p]),
            .gate_lo_o (gate_lo[p])
        );
    end

    // R6: no gate can be on before a configuration is loaded.
    a_r6_off_until_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_loaded |-> ((gate_hi == '0) && (gate_lo == '0)));
endmodule

// File: tb/hcc_ctrl_tb.sv
`timescale 1ns/1ps
module hcc_ctrl_tb;
    localparam int W = 12;
    localparam int P = 3;
    localparam int DT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic cfg_load = 1'b0;
    logic [W-1:0] hyst_in = '0;
    logic [P*W-1:0] ref_in = '0;
    logic [P*W-1:0] fb_in = '0;
    logic [P-1:0] fb_valid = '0;
    logic [P-1:0] gate_hi, gate_lo;

    hcc_ctrl #(.W(W), .PHASES(P), .DEAD_CYC(DT)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_load(cfg_load),
        .hyst_in(hyst_in), .ref_in(ref_in), .fb_in(fb_in), .fb_valid(fb_valid),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int mdir [P];       // 0 none, 1 up, 2 down
    int mh = 0;
    bit mloaded = 0;
    bit men = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Apply one valid sample on phase p; returns after the sampling edge (at negedge).
    task automatic sample(input int p, input int r, input int f);
        ref_in[p*W +: W] = W'(r);
        fb_in[p*W +: W]  = W'(sat(f));
        fb_valid[p] = 1'b1;
        tick(1);
        fb_valid[p] = 1'b0;
        if (mloaded) begin
            if (sat(f) > sat(r + mh)) mdir[p] = 2;
            else if (sat(f) < sat(r - mh)) mdir[p] = 1;
        end
    endtask

    task automatic load(input int h);
        hyst_in = W'(h);
        cfg_load = 1'b1;
        tick(1);
        cfg_load = 1'b0;
        mh = h;
        mloaded = 1;
    endtask

    function automatic int gcode(input int p);
        return {30'd0, gate_lo[p], gate_hi[p]};
    endfunction

    function automatic int ecode(input int p);
        if (!men) return 0;
        return (mdir[p] == 1) ? 1 : (mdir[p] == 2) ? 2 : 0;
    endfunction

    task automatic check_all(input string tag);
        for (int p = 0; p < P; p++)
            check(gcode(p) == ecode(p), tag, gcode(p), ecode(p));
    endtask

    // Monitor: overlap and blanking length seen at the ports.
    int low_run [P];
    int mon_fail = 0;
    initial for (int p = 0; p < P; p++) low_run[p] = 0;
    always @(negedge clk) begin
        for (int p = 0; p < P; p++) begin
            if (gate_hi[p] && gate_lo[p]) mon_fail++;
            if (gate_hi[p] || gate_lo[p]) begin
                if (low_run[p] > 0 && low_run[p] < DT) mon_fail++;
                low_run[p] = 0;
            end else begin
                low_run[p]++;
            end
        end
    end

    initial begin
        #(20ns * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int refs [10] = '{-2048, -2040, -1000, -1, 0, 1, 500, 2000, 2040, 2047};
        int hs [5] = '{0, 1, 37, 100, 2047};
        int offs [6] = '{-1, 0, 1, 2, 3, 4};
        int k;
        for (int p = 0; p < P; p++) mdir[p] = 0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        check(gate_hi == 0 && gate_lo == 0, "R1 reset gates", {gate_hi, gate_lo}, 0);

        // R6: samples before configuration are ignored
        enable = 1'b1; men = 1;
        sample(0, 0, -500);
        sample(1, 0, 500);
        tick(DT + 4);
        check(gate_hi == 0 && gate_lo == 0, "R6 unloaded ignores samples", {gate_hi, gate_lo}, 0);
        load(50);
        tick(DT + 4);
        check(gate_hi == 0 && gate_lo == 0, "R6 loaded but no direction", {gate_hi, gate_lo}, 0);

        // R8: first direction from off; sample edge e, rise at e+DT+1
        sample(0, 0, -100);             // now just after edge e
        tick(DT);                        // after edge e+DT
        check(gcode(0) == 0, "R8 still blanking before rise", gcode(0), 0);
        tick(1);                         // after edge e+DT+1
        check(gcode(0) == 1, "R8 high gate rises on time", gcode(0), 1);

        // R7: reversal; old on after e, both low from e+1, new at e+DT+2
        sample(0, 0, 100);
        check(gcode(0) == 1, "R7 old gate held at sample edge", gcode(0), 1);
        tick(1);
        check(gcode(0) == 0, "R7 both low after drop", gcode(0), 0);
        tick(DT);
        check(gcode(0) == 0, "R7 still blanking", gcode(0), 0);
        tick(1);
        check(gcode(0) == 2, "R7 low gate rises on time", gcode(0), 2);

        // R4: inclusive band edges hold (h=50, ref=0)
        sample(0, 0, 50);
        tick(DT + 4);
        check(gcode(0) == 2, "R4 at upper edge holds", gcode(0), 2);
        sample(0, 0, -50);
        tick(DT + 4);
        check(gcode(0) == 2, "R4 at lower edge holds", gcode(0), 2);

        // R5: out-of-band inputs without valid strobe do nothing
        fb_in[0 +: W] = W'(-900);
        tick(DT + 6);
        check(gcode(0) == 2, "R5 no strobe no change", gcode(0), 2);

        // R11: new half-width used after load
        sample(0, 0, -70);               // h=50: below -> up
        tick(DT + 4);
        check(gcode(0) == 1, "R11 old band excursion", gcode(0), 1);
        load(100);
        sample(0, 0, 70);                // h=100: inside -> hold up
        tick(DT + 4);
        check(gcode(0) == 1, "R11 new band applied", gcode(0), 1);

        // R2: saturation corners distinguish clamping from wrap
        load(100);
        sample(1, 2040, 2047);           // upper clamps to 2047, inside
        tick(DT + 4);
        check(gcode(1) == 0, "R2 upper clamp no wrap", gcode(1), 0);
        sample(1, -2040, -2048);         // lower clamps to -2048, inside
        tick(DT + 4);
        check(gcode(1) == 0, "R2 lower clamp no wrap", gcode(1), 0);

        // R9: disable forces off, direction retained, re-enable after DT
        sample(2, 0, 300);
        tick(DT + 4);
        enable = 1'b0; men = 0;
        tick(1);
        check(gate_hi == 0 && gate_lo == 0, "R9 disable clears gates", {gate_hi, gate_lo}, 0);
        tick(5);
        enable = 1'b1; men = 1;
        tick(DT);                        // after edge a+DT-1
        check(gate_hi == 0 && gate_lo == 0, "R9 blanking after enable", {gate_hi, gate_lo}, 0);
        tick(1);                         // after edge a+DT
        check_all("R9 directions restored");

        // R2/R3/R4/R10: sweep references, half-widths and edge offsets
        k = 0;
        foreach (hs[i]) begin
            load(hs[i]);
            foreach (refs[j]) begin
                foreach (offs[o]) begin
                    int f;
                    int pp = k % P;
                    case (offs[o])
                        -1: f = refs[j] - hs[i] - 1;
                        0:  f = refs[j] - hs[i];
                        1:  f = refs[j];
                        2:  f = refs[j] + hs[i];
                        3:  f = refs[j] + hs[i] + 1;
                        default: f = (k % 2) ? 2047 : -2048;
                    endcase
                    sample(pp, refs[j], f);
                    tick(DT + 4);
                    check_all("R3 sweep gates (R2 R4 R10)");
                    k++;
                end
            end
        end

        check(mon_fail == 0, "R7 monitor overlap or short blank", mon_fail, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule